// File: doc/BRIEF.md
# Video Memory DMA Engine

This engine performs bulk transfers into the three video memories after the command port requests a DMA transfer. It takes the length, the source and the mode from a bank of byte-wide registers. It then moves one unit per clock and steps the destination address by the auto-increment value after each unit. Three operations are supported. A memory transfer reads words from a source memory and writes them into video RAM, the 64-entry colour RAM or the 64-entry scroll RAM. A fill is armed by the command and then started by the next data-port write; it writes one byte value into a run of video RAM bytes. A copy moves bytes from one place in video RAM to another.

When the last unit has been moved, the engine pulses `done_o` for one cycle. During that cycle it presents two values for the register file to load: the advanced low source address and the final destination address. The register file clears the length registers on that pulse. Bus arbitration and CPU stalling belong to the surrounding logic.

Top module: `vdma_engine`

## Requirements
- R1: A `cmd_start_i` pulse while `dma_en_i` is low starts nothing. No memory write and no `done_o` pulse follows it.
- R2: The unit count is `{len_hi_i,len_lo_i}`, and a value of 0 means 65536. The engine moves one unit per clock, starting in the cycle after the starting pulse, and `done_o` is high for exactly one cycle, in the cycle after the last unit.
- R3: The mode is taken from `src_hi_i[7:6]`. The value 2'b00 or 2'b01 selects a memory transfer, 2'b10 selects a fill and 2'b11 selects a copy.
- R4: In a memory transfer, unit k reads the source word at the word address `{src_hi_i[6:0],src_mid_i,src_lo_i}+k`. The value of `tgt_i` picks the destination: 1 selects video RAM, 2 colour RAM, 3 scroll RAM. The value 0 writes nothing but still advances the address.
- R5: Video RAM is byte addressed. The even byte of a word pair sits on lane `[15:8]` with write enable `vram_be_o[1]`, and the odd byte sits on lane `[7:0]` with `vram_be_o[0]`. A memory-transfer word goes to the pair that holds the destination, and it is byte-swapped when the destination is odd.
- R6: The colour RAM index and the scroll RAM index are both the destination address bits [6:1], so they wrap modulo 64.
- R7: After each unit the destination advances by the 8-bit `inc_i`, modulo 65536.
- R8: A fill command arms the engine, and nothing is written or flagged busy until `data_wr_i`. The fill then starts at the `addr_i` value present with that write and stores `fill_data_i` at each destination byte of video RAM. A fill aimed at colour RAM or scroll RAM writes nothing but still advances the address.
- R9: A copy reads video RAM byte `{src_mid_i,src_lo_i}+k` (mod 65536) and writes it to the destination. The units are processed in order, so a later read sees the result of an earlier write.
- R10: With `done_o`, `src_wb_o` equals the low 16 source bits plus the unit count, mod 65536, and `addr_wb_o` equals the destination address after the last step.
- R11: `busy_o` is high in exactly the unit cycles of a fill or a copy. It stays low during a memory transfer and while a fill is armed.
- R12: A `cmd_start_i` pulse that arrives while a transfer is running is ignored.
- R13: At most one of the three memory ports is written in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_en_i | input | 1 | DMA enable bit from the mode register |
| inc_i | input | 8 | Auto-increment value |
| len_lo_i | input | 8 | Unit count, low byte |
| len_hi_i | input | 8 | Unit count, high byte |
| src_lo_i | input | 8 | Source address, low byte |
| src_mid_i | input | 8 | Source address, middle byte |
| src_hi_i | input | 8 | Source address high bits and mode field [7:6] |
| cmd_start_i | input | 1 | Pulse: a command requested DMA |
| tgt_i | input | 2 | Destination memory code |
| addr_i | input | 16 | Current port destination address |
| data_wr_i | input | 1 | Pulse: data-port write (starts an armed fill) |
| fill_data_i | input | 8 | Upper byte of the data-port word |
| src_addr_o | output | 23 | Source memory word address |
| src_data_i | input | 16 | Source memory read data (same cycle) |
| vram_we_o | output | 1 | Video RAM write strobe |
| vram_addr_o | output | 16 | Video RAM byte write address |
| vram_be_o | output | 2 | Video RAM byte lane enables |
| vram_wdata_o | output | 16 | Video RAM write data |
| vram_raddr_o | output | 16 | Video RAM byte read address (copy) |
| vram_rdata_i | input | 8 | Video RAM read byte (same cycle) |
| cram_we_o | output | 1 | Colour RAM write strobe |
| cram_idx_o | output | 6 | Colour RAM index |
| cram_wdata_o | output | 16 | Colour RAM write data |
| vsram_we_o | output | 1 | Scroll RAM write strobe |
| vsram_idx_o | output | 6 | Scroll RAM index |
| vsram_wdata_o | output | 16 | Scroll RAM write data |
| busy_o | output | 1 | Fill or copy in progress |
| done_o | output | 1 | Pulse: transfer finished, write-back valid |
| src_wb_o | output | 16 | Advanced low source address |
| addr_wb_o | output | 16 | Final destination address |

## Verification
Every run is checked against a full 64 KiB model of video RAM and against both small RAMs. Memory transfers go to even and to odd destinations, which separates a correct byte swap from a missing or inverted one. Increments of 2, 6 and 128 are combined with starting points near the top of the address space, which exposes errors in index wrap and address wrap. Overlapping copies separate in-order byte processing from buffered reads. A fill whose data-write address differs from its command address shows which of the two addresses is latched. A length of zero tells a 65536-unit run apart from an empty one. Further runs cover the enable gate, a command arriving in mid-run and a fill aimed at colour RAM, and each of these must leave the memories untouched.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_RUN} state_t;
  typedef enum logic [1:0] {MD_MEM, MD_FILL, MD_COPY} op_t;
  typedef enum logic [1:0] {TG_NONE = 2'd0, TG_VRAM = 2'd1, TG_CRAM = 2'd2, TG_VSRAM = 2'd3} tgt_t;
endpackage

// File: rtl/vdma_decode.sv
module vdma_decode
  import vdma_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic [REG_W-1:0]   len_lo_i,
  input  logic [REG_W-1:0]   len_hi_i,
  input  logic [REG_W-1:0]   src_lo_i,
  input  logic [REG_W-1:0]   src_mid_i,
  input  logic [REG_W-1:0]   src_hi_i,
  output logic [2*REG_W:0]   units_o,
  output logic [3*REG_W-2:0] src_word_o,
  output op_t                op_o
);
  localparam int LEN_W = 2 * REG_W;

  logic [LEN_W-1:0] len;

  assign len        = {len_hi_i, len_lo_i};
  // zero length encodes the full 2^LEN_W range
  assign units_o    = (len == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, len};
  assign src_word_o = {src_hi_i[REG_W-2:0], src_mid_i, src_lo_i};

  always_comb begin
    unique case (src_hi_i[REG_W-1 -: 2])
      2'b10:   op_o = MD_FILL;
      2'b11:   op_o = MD_COPY;
      default: op_o = MD_MEM;
    endcase
  end
endmodule

// File: rtl/vdma_seq.sv
module vdma_seq
  import vdma_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int ADDR_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_start_i,
  input  logic                 dma_en_i,
  input  logic                 data_wr_i,
  input  logic [REG_W-1:0]     fill_data_i,
  input  tgt_t                 tgt_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [REG_W-1:0]     inc_i,
  input  logic [2*REG_W:0]     units_i,
  input  logic [3*REG_W-2:0]   src_word_i,
  input  op_t                  op_i,
  output logic                 run_o,
  output op_t                  op_o,
  output tgt_t                 tgt_o,
  output logic [ADDR_W-1:0]    dst_o,
  output logic [3*REG_W-2:0]   src_o,
  output logic [REG_W-1:0]     fill_o,
  output logic                 busy_o,
  output logic                 done_o
);
  localparam int LEN_W = 2 * REG_W;
  localparam int CNT_W = LEN_W + 1;
  localparam int SRC_W = 3 * REG_W - 1;
  localparam logic [CNT_W-1:0] MAX_UNITS = {1'b1, {LEN_W{1'b0}}};

  state_t             state_q;
  op_t                op_q;
  tgt_t               tgt_q;
  logic [ADDR_W-1:0]  dst_q;
  logic [SRC_W-1:0]   src_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [REG_W-1:0]   inc_q;
  logic [REG_W-1:0]   fill_q;
  logic               done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= MD_MEM;
      tgt_q   <= TG_NONE;
      dst_q   <= '0;
      src_q   <= '0;
      cnt_q   <= '0;
      inc_q   <= '0;
      fill_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE, ST_ARMED: begin
          if (cmd_start_i && dma_en_i) begin
            op_q    <= op_i;
            tgt_q   <= tgt_i;
            dst_q   <= addr_i;
            src_q   <= src_word_i;
            cnt_q   <= units_i;
            inc_q   <= inc_i;
            state_q <= (op_i == MD_FILL) ? ST_ARMED : ST_RUN;
          end else if (state_q == ST_ARMED && data_wr_i) begin
            // fill takes address, length and source at the data write
            dst_q   <= addr_i;
            src_q   <= src_word_i;
            cnt_q   <= units_i;
            inc_q   <= inc_i;
            fill_q  <= fill_data_i;
            state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          dst_q <= dst_q + ADDR_W'(inc_q);
          src_q <= src_q + 1'b1;
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o  = (state_q == ST_RUN);
  assign op_o   = op_q;
  assign tgt_o  = tgt_q;
  assign dst_o  = dst_q;
  assign src_o  = src_q;
  assign fill_o = fill_q;
  assign busy_o = (state_q == ST_RUN) && (op_q != MD_MEM);
  assign done_o = done_q;

  a_r1_enable_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && cmd_start_i && !dma_en_i) |=> (state_q == ST_IDLE));

  a_r12_cmd_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && cnt_q != CNT_W'(1) && cmd_start_i)
      |=> (state_q == ST_RUN && op_q == $past(op_q) && tgt_q == $past(tgt_q)));

  a_r2_count_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> (cnt_q != '0 && cnt_q <= MAX_UNITS));

  a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/vdma_route.sv
module vdma_route
  import vdma_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 6
) (
  input  logic                        valid_i,
  input  op_t                         op_i,
  input  tgt_t                        tgt_i,
  input  logic [ADDR_W-1:0]           dst_i,
  input  logic [3*REG_W-2:0]          src_i,
  input  logic [REG_W-1:0]            fill_i,
  input  logic [2*REG_W-1:0]          src_data_i,
  input  logic [REG_W-1:0]            vram_rdata_i,
  output logic [3*REG_W-2:0]          src_addr_o,
  output logic                        vram_we_o,
  output logic [ADDR_W-1:0]           vram_addr_o,
  output logic [1:0]                  vram_be_o,
  output logic [2*REG_W-1:0]          vram_wdata_o,
  output logic [ADDR_W-1:0]           vram_raddr_o,
  output logic [1:0]                  small_we_o,
  output logic [1:0][IDX_W-1:0]       small_idx_o,
  output logic [2*REG_W-1:0]          small_wdata_o
);
  localparam int DW = 2 * REG_W;

  logic [1:0] byte_be;

  assign src_addr_o   = src_i;
  assign vram_addr_o  = dst_i;
  assign vram_raddr_o = src_i[ADDR_W-1:0];
  // even byte address lives on the upper lane
  assign byte_be      = dst_i[0] ? 2'b01 : 2'b10;

  always_comb begin
    vram_we_o    = 1'b0;
    vram_be_o    = 2'b00;
    vram_wdata_o = '0;
    if (valid_i) begin
      unique case (op_i)
        MD_MEM: if (tgt_i == TG_VRAM) begin
          vram_we_o    = 1'b1;
          vram_be_o    = 2'b11;
          vram_wdata_o = dst_i[0] ? {src_data_i[REG_W-1:0], src_data_i[DW-1:REG_W]}
                                  : src_data_i;
        end
        MD_FILL: if (tgt_i == TG_VRAM) begin
          vram_we_o    = 1'b1;
          vram_be_o    = byte_be;
          vram_wdata_o = {fill_i, fill_i};
        end
        MD_COPY: begin
          vram_we_o    = 1'b1;
          vram_be_o    = byte_be;
          vram_wdata_o = {vram_rdata_i, vram_rdata_i};
        end
        default: ;
      endcase
    end
  end

  assign small_wdata_o = src_data_i;

  for (genvar g = 0; g < 2; g++) begin : g_small
    localparam tgt_t CODE = (g == 0) ? TG_CRAM : TG_VSRAM;
    assign small_we_o[g]  = valid_i && (op_i == MD_MEM) && (tgt_i == CODE);
    assign small_idx_o[g] = dst_i[IDX_W:1];
  end
endmodule

// File: rtl/vdma_engine.sv
module vdma_engine
  import vdma_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int ADDR_W      = 2 * REG_W,
  parameter int SMALL_DEPTH = 64,
  localparam int IDX_W      = $clog2(SMALL_DEPTH),
  localparam int SRC_W      = 3 * REG_W - 1,
  localparam int DW         = 2 * REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dma_en_i,
  input  logic [REG_W-1:0]  inc_i,
  input  logic [REG_W-1:0]  len_lo_i,
  input  logic [REG_W-1:0]  len_hi_i,
  input  logic [REG_W-1:0]  src_lo_i,
  input  logic [REG_W-1:0]  src_mid_i,
  input  logic [REG_W-1:0]  src_hi_i,
  input  logic              cmd_start_i,
  input  logic [1:0]        tgt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_wr_i,
  input  logic [REG_W-1:0]  fill_data_i,
  output logic [SRC_W-1:0]  src_addr_o,
  input  logic [DW-1:0]     src_data_i,
  output logic              vram_we_o,
  output logic [ADDR_W-1:0] vram_addr_o,
  output logic [1:0]        vram_be_o,
  output logic [DW-1:0]     vram_wdata_o,
  output logic [ADDR_W-1:0] vram_raddr_o,
  input  logic [REG_W-1:0]  vram_rdata_i,
  output logic              cram_we_o,
  output logic [IDX_W-1:0]  cram_idx_o,
  output logic [DW-1:0]     cram_wdata_o,
  output logic              vsram_we_o,
  output logic [IDX_W-1:0]  vsram_idx_o,
  output logic [DW-1:0]     vsram_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DW-1:0]     src_wb_o,
  output logic [ADDR_W-1:0] addr_wb_o
);
  logic [DW:0]            units;
  logic [SRC_W-1:0]       src_word;
  op_t                    dec_op;
  logic                   run;
  op_t                    run_op;
  tgt_t                   run_tgt;
  logic [ADDR_W-1:0]      dst;
  logic [SRC_W-1:0]       src;
  logic [REG_W-1:0]       fill_byte;
  logic [1:0]             small_we;
  logic [1:0][IDX_W-1:0]  small_idx;
  logic [DW-1:0]          small_wdata;

  vdma_decode #(.REG_W(REG_W)) u_decode (
    .len_lo_i   (len_lo_i),
    .len_hi_i   (len_hi_i),
    .src_lo_i   (src_lo_i),
    .src_mid_i  (src_mid_i),
    .src_hi_i   (src_hi_i),
    .units_o    (units),
    .src_word_o (src_word),
    .op_o       (dec_op)
  );

  vdma_seq #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_start_i (cmd_start_i),
    .dma_en_i    (dma_en_i),
    .data_wr_i   (data_wr_i),
    .fill_data_i (fill_data_i),
    .tgt_i       (tgt_t'(tgt_i)),
    .addr_i      (addr_i),
    .inc_i       (inc_i),
    .units_i     (units),
    .src_word_i  (src_word),
    .op_i        (dec_op),
    .run_o       (run),
    .op_o        (run_op),
    .tgt_o       (run_tgt),
    .dst_o       (dst),
    .src_o       (src),
    .fill_o      (fill_byte),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  vdma_route #(.REG_W(REG_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_route (
    .valid_i       (run),
    .op_i          (run_op),
    .tgt_i         (run_tgt),
    .dst_i         (dst),
    .src_i         (src),
    .fill_i        (fill_byte),
    .src_data_i    (src_data_i),
    .vram_rdata_i  (vram_rdata_i),
    .src_addr_o    (src_addr_o),
    .vram_we_o     (vram_we_o),
    .vram_addr_o   (vram_addr_o),
    .vram_be_o     (vram_be_o),
    .vram_wdata_o  (vram_wdata_o),
    .vram_raddr_o  (vram_raddr_o),
    .small_we_o    (small_we),
    .small_idx_o   (small_idx),
    .small_wdata_o (small_wdata)
  );

  assign cram_we_o     = small_we[0];
  assign cram_idx_o    = small_idx[0];
  assign cram_wdata_o  = small_wdata;
  assign vsram_we_o    = small_we[1];
  assign vsram_idx_o   = small_idx[1];
  assign vsram_wdata_o = small_wdata;
  assign src_wb_o      = src[DW-1:0];
  assign addr_wb_o     = dst;

  a_r13_single_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({vram_we_o, cram_we_o, vsram_we_o}));

  a_r11_small_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cram_we_o || vsram_we_o) |-> !busy_o);

  a_r8_no_write_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !$past(cmd_start_i)) |-> !(vram_we_o || cram_we_o || vsram_we_o));
endmodule

// File: tb/vdma_engine_test.sv
module vdma_engine_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dma_en = 1'b0;
  logic [7:0]  inc = '0, len_lo = '0, len_hi = '0, src_lo = '0, src_mid = '0, src_hi = '0;
  logic        cmd_start = 1'b0;
  logic [1:0]  tgt = '0;
  logic [15:0] addr = '0;
  logic        data_wr = 1'b0;
  logic [7:0]  fill_data = '0;
  logic [22:0] src_addr;
  logic [15:0] src_data;
  logic        vram_we;
  logic [15:0] vram_addr, vram_wdata, vram_raddr;
  logic [1:0]  vram_be;
  logic [7:0]  vram_rdata;
  logic        cram_we, vsram_we;
  logic [5:0]  cram_idx, vsram_idx;
  logic [15:0] cram_wdata, vsram_wdata;
  logic        busy, done;
  logic [15:0] src_wb, addr_wb;

  int errs = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vdma_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .dma_en_i(dma_en), .inc_i(inc),
    .len_lo_i(len_lo), .len_hi_i(len_hi), .src_lo_i(src_lo), .src_mid_i(src_mid),
    .src_hi_i(src_hi), .cmd_start_i(cmd_start), .tgt_i(tgt), .addr_i(addr),
    .data_wr_i(data_wr), .fill_data_i(fill_data), .src_addr_o(src_addr),
    .src_data_i(src_data), .vram_we_o(vram_we), .vram_addr_o(vram_addr),
    .vram_be_o(vram_be), .vram_wdata_o(vram_wdata), .vram_raddr_o(vram_raddr),
    .vram_rdata_i(vram_rdata), .cram_we_o(cram_we), .cram_idx_o(cram_idx),
    .cram_wdata_o(cram_wdata), .vsram_we_o(vsram_we), .vsram_idx_o(vsram_idx),
    .vsram_wdata_o(vsram_wdata), .busy_o(busy), .done_o(done),
    .src_wb_o(src_wb), .addr_wb_o(addr_wb)
  );

  function automatic logic [15:0] srcf(input logic [22:0] a);
    logic [15:0] r;
    r = a[15:0] * 16'h9E37;
    return r ^ {9'h0, a[22:16]};
  endfunction

  function automatic logic [7:0] vpat(input int i);
    return 8'(i * 7 + 3);
  endfunction

  function automatic logic [15:0] spat(input int i, input int salt);
    return 16'(i * 16'h0101 + salt);
  endfunction

  // design-side memories
  logic [7:0]  vmem  [0:65535];
  logic [15:0] cmem  [0:63];
  logic [15:0] smem  [0:63];
  // expected memories
  logic [7:0]  emem  [0:65535];
  logic [15:0] ecmem [0:63];
  logic [15:0] esmem [0:63];

  assign src_data   = srcf(src_addr);
  assign vram_rdata = vmem[vram_raddr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 65536; i++) vmem[i] <= vpat(i);
      for (int i = 0; i < 64; i++) begin
        cmem[i] <= spat(i, 16'h1111);
        smem[i] <= spat(i, 16'h2222);
      end
    end else begin
      if (vram_we) begin
        if (vram_be[1]) vmem[{vram_addr[15:1], 1'b0}] <= vram_wdata[15:8];
        if (vram_be[0]) vmem[{vram_addr[15:1], 1'b1}] <= vram_wdata[7:0];
      end
      if (cram_we)  cmem[cram_idx]  <= cram_wdata;
      if (vsram_we) smem[vsram_idx] <= vsram_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_mem(input string tag);
    int bad = 0;
    int fa = -1;
    int fv = 0;
    int fe = 0;
    for (int i = 0; i < 65536; i++)
      if (vmem[i] !== emem[i]) begin
        if (fa < 0) begin fa = i; fv = int'(vmem[i]); fe = int'(emem[i]); end
        bad++;
      end
    for (int i = 0; i < 64; i++) begin
      if (cmem[i] !== ecmem[i]) begin
        if (fa < 0) begin fa = 16'h8000 + i; fv = int'(cmem[i]); fe = int'(ecmem[i]); end
        bad++;
      end
      if (smem[i] !== esmem[i]) begin
        if (fa < 0) begin fa = 16'h9000 + i; fv = int'(smem[i]); fe = int'(esmem[i]); end
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      errs++;
      $display("FAIL %s: %0d cells differ, first at %0h actual=%0h expected=%0h",
               tag, bad, fa, fv, fe);
    end
  endtask

  // reference models
  task automatic ref_mem(input int tg, input logic [15:0] a0, input logic [7:0] st,
                         input int n, input logic [22:0] s, output logic [15:0] af);
    logic [15:0] a = a0;
    for (int k = 0; k < n; k++) begin
      logic [15:0] w, d;
      w = srcf(s + 23'(k));
      if (tg == 1) begin
        d = a[0] ? {w[7:0], w[15:8]} : w;
        emem[{a[15:1], 1'b0}] = d[15:8];
        emem[{a[15:1], 1'b1}] = d[7:0];
      end else if (tg == 2) ecmem[a[6:1]] = w;
      else if (tg == 3) esmem[a[6:1]] = w;
      a = a + 16'(st);
    end
    af = a;
  endtask

  task automatic ref_fill(input int tg, input logic [15:0] a0, input logic [7:0] st,
                          input int n, input logic [7:0] b, output logic [15:0] af);
    logic [15:0] a = a0;
    for (int k = 0; k < n; k++) begin
      if (tg == 1) emem[a] = b;
      a = a + 16'(st);
    end
    af = a;
  endtask

  task automatic ref_copy(input logic [15:0] a0, input logic [7:0] st, input int n,
                          input logic [15:0] s0, output logic [15:0] af);
    logic [15:0] a = a0;
    logic [15:0] s = s0;
    for (int k = 0; k < n; k++) begin
      emem[a] = emem[s];
      a = a + 16'(st);
      s = s + 16'd1;
    end
    af = a;
  endtask

  int          r_cyc, r_busy, r_wr, r_pre;
  logic [15:0] r_src, r_addr;

  task automatic go(input logic [7:0] hi, input logic [7:0] mid, input logic [7:0] lo,
                    input logic [15:0] len, input logic [1:0] tg, input logic [15:0] a,
                    input logic [7:0] st, input bit is_fill, input logic [15:0] fa,
                    input logic [7:0] fb, input int inj);
    r_cyc = 0; r_busy = 0; r_wr = 0; r_pre = 0; r_src = '0; r_addr = '0;
    @(negedge clk);
    dma_en = 1'b1; src_hi = hi; src_mid = mid; src_lo = lo;
    len_hi = len[15:8]; len_lo = len[7:0]; tgt = tg; addr = a; inc = st;
    cmd_start = 1'b1;
    if (is_fill) begin
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        cmd_start = 1'b0;
        if (busy || vram_we || cram_we || vsram_we || done) r_pre++;
      end
      addr = fa; fill_data = fb; data_wr = 1'b1;
    end
    while (1) begin
      @(negedge clk);
      cmd_start = 1'b0;
      data_wr = 1'b0;
      src_hi = hi;
      r_cyc++;
      if (busy) r_busy++;
      if (vram_we || cram_we || vsram_we) r_wr++;
      if (done) begin r_src = src_wb; r_addr = addr_wb; break; end
      if (inj == r_cyc) begin cmd_start = 1'b1; src_hi = 8'hC0; end
      if (r_cyc > 70000) break;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [15:0] ea;
    for (int i = 0; i < 65536; i++) emem[i] = vpat(i);
    for (int i = 0; i < 64; i++) begin
      ecmem[i] = spat(i, 16'h1111);
      esmem[i] = spat(i, 16'h2222);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(!busy, "R11 reset busy", int'(busy), 0);
    chk(!done, "R2 reset done", int'(done), 0);
    chk(!(vram_we || cram_we || vsram_we), "R13 reset writes",
        int'({vram_we, cram_we, vsram_we}), 0);

    // R5: memory to video RAM, even start, mode 00
    go(8'h01, 8'h23, 8'h45, 16'd8, 2'd1, 16'h1000, 8'd2, 0, 0, 0, 0);
    ref_mem(1, 16'h1000, 8'd2, 8, 23'h012345, ea);
    cmp_mem("R5 even vram words");
    chk(r_cyc == 9, "R2 unit timing", r_cyc, 9);
    chk(r_src == 16'h234D, "R10 src writeback", r_src, 16'h234D);
    chk(r_addr == ea, "R7 addr writeback", r_addr, ea);
    chk(r_busy == 0, "R11 no busy in memory transfer", r_busy, 0);

    // R3/R5: mode 01, odd destination, source bit 22 set
    go(8'h41, 8'h80, 8'h10, 16'd5, 2'd1, 16'h2001, 8'd2, 0, 0, 0, 0);
    ref_mem(1, 16'h2001, 8'd2, 5, {7'h41, 8'h80, 8'h10}, ea);
    cmp_mem("R3 R5 odd swap, mode 01");
    chk(r_addr == ea, "R7 odd addr", r_addr, ea);

    // R6: colour RAM wrap
    go(8'h00, 8'h04, 8'h00, 16'd10, 2'd2, 16'h0078, 8'd2, 0, 0, 0, 0);
    ref_mem(2, 16'h0078, 8'd2, 10, 23'h000400, ea);
    cmp_mem("R6 colour wrap");

    // R6/R7: scroll RAM, step 6
    go(8'h00, 8'h05, 8'hF0, 16'd20, 2'd3, 16'h0003, 8'd6, 0, 0, 0, 0);
    ref_mem(3, 16'h0003, 8'd6, 20, 23'h0005F0, ea);
    cmp_mem("R6 scroll wrap");
    chk(r_addr == ea, "R7 scroll addr", r_addr, ea);

    // R4: no target
    go(8'h00, 8'h00, 8'h00, 16'd3, 2'd0, 16'h0500, 8'd4, 0, 0, 0, 0);
    cmp_mem("R4 no target untouched");
    chk(r_wr == 0, "R4 no writes", r_wr, 0);
    chk(r_addr == 16'h050C, "R4 address advanced", r_addr, 16'h050C);

    // R1: enable low
    begin
      int seen = 0;
      @(negedge clk);
      dma_en = 1'b0; src_hi = 8'h00; len_hi = 0; len_lo = 4; tgt = 2'd1; addr = 16'h6000;
      cmd_start = 1'b1;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        cmd_start = 1'b0;
        if (vram_we || cram_we || vsram_we || done || busy) seen++;
      end
      chk(seen == 0, "R1 disabled start", seen, 0);
      cmp_mem("R1 memories untouched");
    end

    // R8: fill, data-write address differs from command address
    go(8'h80, 8'h00, 8'h10, 16'd7, 2'd1, 16'h0100, 8'd1, 1, 16'h3001, 8'hC3, 0);
    ref_fill(1, 16'h3001, 8'd1, 7, 8'hC3, ea);
    cmp_mem("R8 fill bytes");
    chk(r_pre == 0, "R8 armed quiet", r_pre, 0);
    chk(r_busy == 7, "R11 fill busy cycles", r_busy, 7);
    chk(r_src == 16'h0017, "R10 fill src", r_src, 16'h0017);
    chk(r_addr == ea, "R8 fill addr", r_addr, ea);

    // R7: fill with step 128 wrapping the address space
    go(8'h80, 8'h00, 8'h00, 16'd600, 2'd1, 16'h0000, 8'd128, 1, 16'hFF41, 8'h5E, 0);
    ref_fill(1, 16'hFF41, 8'd128, 600, 8'h5E, ea);
    cmp_mem("R7 fill wrap");
    chk(r_addr == ea, "R7 fill wrap addr", r_addr, ea);

    // R8: fill toward colour RAM writes nothing
    go(8'h80, 8'h00, 8'h00, 16'd4, 2'd2, 16'h0000, 8'd2, 1, 16'h0010, 8'hAA, 0);
    cmp_mem("R8 fill colour untouched");
    chk(r_wr == 0, "R8 fill colour writes", r_wr, 0);
    chk(r_addr == 16'h0018, "R8 fill colour addr", r_addr, 16'h0018);

    // R9: overlapping copy, later reads see earlier writes
    go(8'hC0, 8'h10, 8'h00, 16'd16, 2'd0, 16'h1003, 8'd1, 0, 0, 0, 0);
    ref_copy(16'h1003, 8'd1, 16, 16'h1000, ea);
    cmp_mem("R9 overlapping copy");
    chk(r_busy == 16, "R11 copy busy cycles", r_busy, 16);
    chk(r_addr == ea, "R9 copy addr", r_addr, ea);

    // R10: copy with source wrap
    go(8'hC0, 8'hFF, 8'hFE, 16'd6, 2'd1, 16'h7001, 8'd2, 0, 0, 0, 0);
    ref_copy(16'h7001, 8'd2, 6, 16'hFFFE, ea);
    cmp_mem("R9 copy source wrap");
    chk(r_src == 16'h0004, "R10 copy src wrap", r_src, 16'h0004);

    // R12: command during run ignored
    go(8'h00, 8'h08, 8'h00, 16'd20, 2'd1, 16'h4000, 8'd2, 0, 0, 0, 5);
    ref_mem(1, 16'h4000, 8'd2, 20, 23'h000800, ea);
    cmp_mem("R12 mid-run command ignored");
    chk(r_cyc == 21, "R12 run length kept", r_cyc, 21);
    chk(r_addr == ea, "R12 addr", r_addr, ea);

    // R2: zero length means 65536 units
    go(8'h80, 8'h12, 8'h34, 16'd0, 2'd1, 16'h0000, 8'd1, 1, 16'h0000, 8'h3C, 0);
    ref_fill(1, 16'h0000, 8'd1, 65536, 8'h3C, ea);
    cmp_mem("R2 full-range fill");
    chk(r_cyc == 65537, "R2 zero length count", r_cyc, 65537);
    chk(r_src == 16'h1234, "R10 full-range src", r_src, 16'h1234);
    chk(r_addr == 16'h0000, "R7 full-range addr", r_addr, 0);

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule